// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a down-counting interval timer with a three-register bus interface. Software picks a prescale exponent and a run mode, then starts the counter. The counter steps down once per prescaled tick, and the tick period is twice the prescale divisor in clock cycles. When the counter expires, it reloads itself and latches a sticky event flag. A level interrupt is raised while that flag is set and interrupts are enabled.

There are two run modes. In modulus mode the counter restarts from a programmable modulus. In free-running mode it restarts from all ones. An overwrite option makes a modulus write load the counter at once. A control write that only changes the interrupt enable, or only clears the flag, does not disturb the running count. Any other control write restarts the count. The debug-halt and low-power bits are stored and read back but have no effect.

Top module: `pit_timer`

## Requirements
- R1: After reset the control/status register reads 0x0000, the modulus and count registers read 0xFFFF, and `irq` is low.
- R2: The register offsets are 0 for control/status, 2 for modulus and 4 for count. The control/status register holds: enable at bit 0, reload mode at bit 1, event flag at bit 2, interrupt enable at bit 3, overwrite at bit 4, stored-only bits at 5 and 6, and the prescale exponent at bits 11:8. Bit 7 and bits 15:12 read zero.
- R3: While enabled, the count decreases by one every 2^(PRE+1) clock cycles. The first decrement comes 2^(PRE+1) cycles after a restart. While disabled, the count holds.
- R4: A tick that finds the count at zero is an expiry. In the same cycle it sets the event flag and reloads the count with the limit. The limit is the modulus when reload mode is 1 and 0xFFFF when it is 0.
- R5: Writing 1 to control bit 2 clears the event flag. Writing 0 there leaves it unchanged, and software can never set it. An expiry in the same cycle as a clearing write leaves the flag set.
- R6: `irq` is high exactly when the interrupt enable bit and the event flag are both 1.
- R7: A control write is interrupt-only when it differs from the stored register only in bits 2, 3 and the unused bits. Such a write neither reloads the count nor resets the prescaler.
- R8: Every other control write loads the count with the limit given by the newly written reload bit and clears the prescaler. Counting then continues if the new enable bit is 1.
- R9: Writing the modulus clears the event flag. With overwrite set, the written value is loaded into the count at once, in either mode. With overwrite clear and reload mode set, the new modulus is used from the next expiry. With both clear, the count is untouched.
- R10: Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an expiry that lands on the same clock edge as a flag-clearing control write, because the set must win (R5). The stimulus gets there by choosing a modulus of 1 and a prescale exponent of 0, so expiries fall on a known even cycle after a restart. The clearing write, which is interrupt-only, is then issued on exactly that edge. A second timing-sensitive case is a modulus write without overwrite: the bench shows that the old limit finishes its period and the new one takes over only at the following expiry.

// File: rtl/pit_pkg.sv
`timescale 1ns/10ps
package pit_pkg;
  // control/status bit positions (software-visible)
  localparam int CTL_EN      = 0;
  localparam int CTL_RLD     = 1;
  localparam int CTL_FLAG    = 2;
  localparam int CTL_IE      = 3;
  localparam int CTL_OVW     = 4;
  localparam int CTL_DBG     = 5;
  localparam int CTL_DOZE    = 6;
  localparam int CTL_PRE_LSB = 8;

  // register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_MOD  = 2;
  localparam int OFS_CNT  = 4;

  // last prescaler state: the tick period is 2^(pre+1) clock cycles
  function automatic int presc_last(input int pre);
    return (1 << (pre + 1)) - 1;
  endfunction
endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/10ps
module pit_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PS_W = 1 << PRE_W;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_last;

  assign ps_last = PS_W'(pit_pkg::presc_last(int'(pre)));
  assign tick    = run && (ps_q == ps_last);

  always_ff @(posedge clk) begin
    if (!rst_n)       ps_q <= '0;
    else if (restart) ps_q <= '0;
    else if (run)     ps_q <= tick ? '0 : ps_q + PS_W'(1);
  end

  // R3: the smallest period is two cycles, so ticks never come back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/10ps
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // restart beats overwrite, and overwrite beats a tick
  assign expire = tick && !restart && !load && (cnt_q == '0);
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '1;
    else if (restart) cnt_q <= limit;
    else if (load)    cnt_q <= load_val;
    else if (tick)    cnt_q <= expire ? limit : cnt_q - CNT_W'(1);
  end

  p_restart_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == $past(limit));
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_expiry_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(limit));
  p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !restart) |=> cnt_q == $past(load_val));
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/10ps
module pit_timer #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  import pit_pkg::*;

  logic             en_q, rld_q, ie_q, ovw_q, dbg_q, doze_q, flag_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] ctrl_word, restart_mask, limit, cnt;
  logic             wr_ctrl, wr_mod, irq_only, restart, load, next_rld;
  logic             tick, expire;

  // register image and the set of bits whose change forces a restart
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_EN]   = en_q;
    ctrl_word[CTL_RLD]  = rld_q;
    ctrl_word[CTL_FLAG] = flag_q;
    ctrl_word[CTL_IE]   = ie_q;
    ctrl_word[CTL_OVW]  = ovw_q;
    ctrl_word[CTL_DBG]  = dbg_q;
    ctrl_word[CTL_DOZE] = doze_q;
    ctrl_word[CTL_PRE_LSB +: PRE_W] = pre_q;
    restart_mask = '0;
    restart_mask[CTL_EN]   = 1'b1;
    restart_mask[CTL_RLD]  = 1'b1;
    restart_mask[CTL_OVW]  = 1'b1;
    restart_mask[CTL_DBG]  = 1'b1;
    restart_mask[CTL_DOZE] = 1'b1;
    restart_mask[CTL_PRE_LSB +: PRE_W] = '1;
  end

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_mod   = bus_wr && (bus_addr == ADDR_W'(OFS_MOD));
  assign irq_only = wr_ctrl && (((bus_wdata ^ ctrl_word) & restart_mask) == '0);
  assign restart  = wr_ctrl && !irq_only;
  assign load     = wr_mod && ovw_q;
  assign next_rld = restart ? bus_wdata[CTL_RLD] : rld_q;
  assign limit    = next_rld ? mod_q : '1;

  pit_prescaler #(.PRE_W(PRE_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(restart),
    .pre(pre_q), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load(load),
    .load_val(bus_wdata), .limit(limit), .tick(tick),
    .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; rld_q <= 1'b0; ie_q <= 1'b0; ovw_q <= 1'b0;
      dbg_q <= 1'b0; doze_q <= 1'b0; pre_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= bus_wdata[CTL_EN];
      rld_q  <= bus_wdata[CTL_RLD];
      ie_q   <= bus_wdata[CTL_IE];
      ovw_q  <= bus_wdata[CTL_OVW];
      dbg_q  <= bus_wdata[CTL_DBG];
      doze_q <= bus_wdata[CTL_DOZE];
      pre_q  <= bus_wdata[CTL_PRE_LSB +: PRE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mod_q <= '1;
    else if (wr_mod) mod_q <= bus_wdata;
  end

  // an expiry always wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                                        flag_q <= 1'b0;
    else if (expire)                                   flag_q <= 1'b1;
    else if ((wr_ctrl && bus_wdata[CTL_FLAG]) || wr_mod) flag_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CTRL): bus_rdata = ctrl_word;
      ADDR_W'(OFS_MOD):  bus_rdata = mod_q;
      ADDR_W'(OFS_CNT):  bus_rdata = cnt;
      default:           bus_rdata = '0;
    endcase
  end

  assign irq = ie_q && flag_q;

  p_flag_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[CTL_FLAG] && !expire) |=> !flag_q);
  p_flag_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !expire) |=> !flag_q);
  p_irq_only_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_only && !tick) |=> $stable(cnt));
  p_mod_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mod && !expire) |=> !flag_q);
  p_cnt_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CNT) && !tick) |=> $stable(cnt));
endmodule

// File: tb/test_pit_timer.sv
`timescale 1ns/10ps
module test_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
    logic        irq_exp;
  } item_t;

  item_t sb_q[$];
  event  ev_chk;

  always #2 clk = ~clk;

  pit_timer i_pit_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [2:0] A_CTL = 3'd0, A_MOD = 3'd2, A_CNT = 3'd4;

  // expected tick period in clocks for a prescale exponent
  function automatic int period(input int pre);
    int d = 2;
    for (int i = 0; i < pre; i++) d = d * 2;
    return d;
  endfunction

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic chk(input logic [2:0] a, input logic [15:0] e,
                     input logic ie, input string tag);
    item_t it;
    bus_addr = a;
    #0.1;
    it.tag = tag; it.exp = e; it.irq_exp = ie;
    sb_q.push_back(it);
    -> ev_chk;
    #0.1;
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(ev_chk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (bus_rdata !== it.exp || irq !== it.irq_exp) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, bus_rdata, irq, it.exp, it.irq_exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(A_CTL, 16'h0000, 1'b0, "R1 ctrl reset");
    chk(A_MOD, 16'hFFFF, 1'b0, "R1 modulus reset");
    chk(A_CNT, 16'hFFFF, 1'b0, "R1 count reset");

    // R9: modulus write, overwrite and reload clear: count untouched
    wr(A_MOD, 16'h0003);
    chk(A_CNT, 16'hFFFF, 1'b0, "R9 no overwrite count kept");
    chk(A_MOD, 16'h0003, 1'b0, "R2 modulus readback");

    // R8 restart in modulus mode, prescale 0 (period 2)
    wr(A_CTL, 16'h000B);
    chk(A_CNT, 16'h0003, 1'b0, "R8 restart loads modulus");
    chk(A_CTL, 16'h000B, 1'b0, "R2 ctrl readback");
    idle(1); chk(A_CNT, 16'h0003, 1'b0, "R3 no early step");
    idle(1); chk(A_CNT, 16'h0002, 1'b0, "R3 first step after period");
    idle(5); chk(A_CNT, 16'h0000, 1'b0, "R3 reaches zero");
    idle(1);
    chk(A_CNT, 16'h0003, 1'b1, "R4 expiry reloads modulus");
    chk(A_CTL, 16'h000F, 1'b1, "R4 R6 flag and irq");

    // R7 interrupt-only writes keep the count phase
    idle(1);
    wr(A_CTL, 16'h0003);
    chk(A_CNT, 16'h0002, 1'b0, "R7 ie off no restart");
    chk(A_CTL, 16'h0007, 1'b0, "R5 R6 zero keeps flag, irq masked");
    wr(A_CTL, 16'h000F);
    chk(A_CTL, 16'h000B, 1'b0, "R5 write one clears flag");
    chk(A_CNT, 16'h0002, 1'b0, "R7 flag clear no restart");
    idle(5);
    chk(A_CNT, 16'h0003, 1'b1, "R4 second expiry");

    // R9 modulus write clears the flag; new limit deferred
    wr(A_MOD, 16'h0001);
    chk(A_CTL, 16'h000B, 1'b0, "R9 modulus write clears flag");
    chk(A_CNT, 16'h0003, 1'b0, "R9 reload mode no overwrite keeps count");
    idle(5); chk(A_CNT, 16'h0000, 1'b0, "R9 old period runs out");
    idle(2); chk(A_CNT, 16'h0001, 1'b1, "R9 new limit at next expiry");
    idle(2); chk(A_CNT, 16'h0000, 1'b1, "R9 new period");

    // R8 overwrite bit change restarts; R9 overwrite in reload mode
    wr(A_CTL, 16'h001B);
    chk(A_CTL, 16'h001F, 1'b1, "R8 restart keeps flag");
    chk(A_CNT, 16'h0001, 1'b1, "R8 restart count");
    wr(A_MOD, 16'h0005);
    chk(A_CNT, 16'h0005, 1'b0, "R9 overwrite loads at once");

    // free-running, prescale 1 (period 4)
    if (period(1) != 4) begin n_fail++; $display("FAIL R3 bench period"); end
    wr(A_CTL, 16'h0111);
    chk(A_CNT, 16'hFFFF, 1'b0, "R8 free-running restart");
    chk(A_CTL, 16'h0111, 1'b0, "R2 prescale field readback");
    idle(3); chk(A_CNT, 16'hFFFF, 1'b0, "R3 prescale 1 no early step");
    idle(1); chk(A_CNT, 16'hFFFE, 1'b0, "R3 prescale 1 step");
    wr(A_MOD, 16'h0010);
    chk(A_CNT, 16'h0010, 1'b0, "R9 free-running overwrite");
    idle(3); chk(A_CNT, 16'h000F, 1'b0, "R9 overwrite keeps prescaler phase");
    wr(A_CNT, 16'h1234);
    chk(A_CNT, 16'h000F, 1'b0, "R10 count write ignored");
    chk(A_CTL, 16'h0111, 1'b0, "R10 ctrl untouched");
    idle(3); chk(A_CNT, 16'h000E, 1'b0, "R10 no restart");
    idle(56); chk(A_CNT, 16'h0000, 1'b0, "R3 free-running zero");
    idle(4);
    chk(A_CNT, 16'hFFFF, 1'b0, "R4 free-running reloads all ones");
    chk(A_CTL, 16'h0115, 1'b0, "R6 flag with ie clear gives no irq");

    // disable, stored-only bits
    wr(A_CTL, 16'h0170);
    chk(A_CTL, 16'h0174, 1'b0, "R2 stored-only bits");
    idle(20); chk(A_CNT, 16'hFFFF, 1'b0, "R3 disabled holds");

    // prescale 3 (period 16), unused bits
    wr(A_CTL, 16'h0303);
    chk(A_CNT, 16'h0010, 1'b0, "R8 reload mode restart");
    idle(15); chk(A_CNT, 16'h0010, 1'b0, "R3 prescale 3 no early step");
    idle(1);  chk(A_CNT, 16'h000F, 1'b0, "R3 prescale 3 step");
    wr(A_CTL, 16'hF383);
    chk(A_CTL, 16'h0307, 1'b0, "R2 unused bits read zero");
    chk(A_CNT, 16'h000F, 1'b0, "R7 unused bits no restart");

    // R5: expiry on the same edge as a clearing write
    wr(A_MOD, 16'h0001);
    chk(A_CTL, 16'h0303, 1'b0, "R9 flag cleared by modulus write");
    wr(A_CTL, 16'h000B);
    chk(A_CNT, 16'h0001, 1'b0, "R8 restart limit 1");
    idle(2); chk(A_CNT, 16'h0000, 1'b0, "R3 limit 1 step");
    idle(1);
    wr(A_CTL, 16'h000F);
    chk(A_CTL, 16'h000F, 1'b1, "R5 expiry beats clear");
    chk(A_CNT, 16'h0001, 1'b1, "R4 reload on coincident edge");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule